// File: doc/BRIEF.md
# Double-Buffered Serial Character Transmitter

This block is the sending half of a programmable asynchronous serial port. It runs from a single clock at a fixed multiple of the bit rate, 16 by default. A character of 5 to 8 bits is placed in a holding register with an active-low load strobe. When the strobe returns high, the character moves on its own into a shift register and goes out on a single serial line as a frame. The frame has a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then one, one and a half, or two high stop bits.

Because holding register and shift register are separate, software can write the next character while the current one is still being sent. The two frames then follow each other with no idle time between them. Two status outputs report when the holding register can accept a new character and when the line has gone fully idle. The frame format comes from a small control register. It follows its inputs on every clock edge while its load input is high. Each frame uses the format held at the moment that frame is moved into the shift register.

Top module: `serial_tx_top`

## Requirements
- R1: While `mrst` is high at a clock edge, `serOut`, `bufEmpty` and `txEmpty` are all high after that edge and any frame in progress is dropped. The control register returns to 8 data bits, parity off, one stop bit.
- R2: The holding register takes `txData` at every edge that samples `bufLoadN` low. The first edge that samples `bufLoadN` high after a low sample clears `bufEmpty`.
- R3: With the line idle, the edge after that rising sample starts the frame: `serOut` goes low and `txEmpty` goes low. `bufEmpty` returns high one edge later.
- R4: A character loaded while a frame is in progress waits in the holding register. Its start bit begins on the same edge that ends the last stop bit, so there is no idle gap, and `txEmpty` stays low across the joint.
- R5: Each start, data and parity bit lasts OSR clock periods. Data bits go out least significant first. The length code `cfgLenSel` 0, 1, 2, 3 selects 5, 6, 7, 8 data bits.
- R6: Bits of `txData` at or above the selected length have no effect on the serial output.
- R7: With `cfgParOff` high there is no parity bit. Otherwise one parity bit follows the data. With `cfgParEven` high the data bits plus the parity bit hold an even number of ones; with it low, an odd number.
- R8: With `cfgStopSel` low there is one stop bit of OSR periods. With it high, the stop time is 1.5 bits (OSR*3/2 periods) for a 5-bit length and 2 bits (2*OSR periods) for 6, 7 or 8 bits.
- R9: `txEmpty` rises on the edge that ends the last stop bit when no character is waiting. While `txEmpty` is high, `serOut` is high.
- R10: The control register follows its inputs at every edge that samples `cfgLoad` high and holds while `cfgLoad` is low. A frame keeps the format it was started with, even if the register changes during that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at OSR times the bit rate |
| mrst | input | 1 | Master reset, active high, synchronous |
| cfgLoad | input | 1 | Control register follows its inputs while high |
| cfgLenSel | input | 2 | Length code: 0..3 selects 5..8 data bits |
| cfgParOff | input | 1 | High removes the parity bit |
| cfgParEven | input | 1 | High selects even parity, low selects odd |
| cfgStopSel | input | 1 | High selects the long stop time |
| bufLoadN | input | 1 | Active-low holding register load; the rising edge requests sending |
| txData | input | DATA_W | Character, right justified |
| serOut | output | 1 | Serial line, high when idle |
| bufEmpty | output | 1 | Holding register free for a new character |
| txEmpty | output | 1 | No frame in progress or waiting |

## Verification
The bench builds the block with its defaults, DATA_W of 8 and OSR of 16. All four length codes are therefore reachable, and the half-bit step needed for the 24-period stop time is a whole number of clocks. The reference model builds every frame as a queue of per-clock line levels and compares the line and both flags on every cycle. The stimulus covers back-to-back frames, a format change in the middle of a frame, and a reset in the middle of a frame.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  localparam int LEN_SEL_W = 2;

  // frame format held by the control register
  typedef struct packed {
    logic [LEN_SEL_W-1:0] lenSel;
    logic                 parOff;
    logic                 parEven;
    logic                 stopSel;
  } txFmt_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic bufWr;
    logic loadFrame;
    logic shiftBit;
  } txStrobe_t;

  localparam txFmt_t FMT_RESET = '{lenSel: 2'b11, parOff: 1'b1, parEven: 1'b0, stopSel: 1'b0};

endpackage

// File: rtl/serial_tx_datapath.sv
module serial_tx_datapath
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              mrst,
  input  logic              cfgLoad,
  input  txFmt_t            cfgIn,
  input  logic [DATA_W-1:0] txData,
  input  txStrobe_t         strobe,
  output txFmt_t            fmtNow,
  output logic              serOut
);

  localparam int MIN_LEN = DATA_W - 3;
  localparam int SH_W    = DATA_W + 1;

  txFmt_t            fmtReg;
  logic [DATA_W-1:0] holdBuf;
  logic [SH_W-1:0]   shiftReg;
  logic [SH_W-1:0]   frameBits;
  logic              outBit;
  logic              parAcc;
  logic              parBit;
  int                charLen;

  // data bits, then parity, with ones above
  always_comb begin
    charLen = MIN_LEN + int'(fmtReg.lenSel);
    parAcc  = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < charLen) parAcc = parAcc ^ holdBuf[i];
    end
    parBit    = fmtReg.parEven ? parAcc : ~parAcc;
    frameBits = '1;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < charLen) frameBits[i] = holdBuf[i];
    end
    for (int i = 0; i < SH_W; i++) begin
      if (!fmtReg.parOff && i == charLen) frameBits[i] = parBit;
    end
  end

  always_ff @(posedge clk) begin
    if (mrst) begin
      fmtReg   <= FMT_RESET;
      holdBuf  <= '0;
      shiftReg <= '1;
      outBit   <= 1'b1;
    end else begin
      if (cfgLoad) fmtReg <= cfgIn;
      if (strobe.bufWr) holdBuf <= txData;
      if (strobe.loadFrame) begin
        outBit   <= 1'b0;
        shiftReg <= frameBits;
      end else if (strobe.shiftBit) begin
        outBit   <= shiftReg[0];
        shiftReg <= {1'b1, shiftReg[SH_W-1:1]};
      end
    end
  end

  assign fmtNow = fmtReg;
  assign serOut = outBit;

  // R3: a frame load always produces the start level
  assert_start_level_R3: assert property (@(posedge clk) disable iff (mrst)
    strobe.loadFrame |=> !serOut);

endmodule

// File: rtl/serial_tx_ctrl.sv
module serial_tx_ctrl
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic                 clk,
  input  logic                 mrst,
  input  logic                 bufLoadN,
  input  logic [LEN_SEL_W-1:0] lenSel,
  input  logic                 parOff,
  input  logic                 stopSel,
  output txStrobe_t            strobe,
  output logic                 bufEmpty,
  output logic                 txEmpty
);

  localparam int MIN_LEN = DATA_W - 3;
  localparam int HALF    = OSR / 2;
  localparam int CNT_W   = $clog2(OSR);
  localparam int BIT_W   = $clog2(DATA_W + 3);
  localparam int HLV_W   = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_BITS, ST_STOP} txState_t;

  txState_t         state;
  logic [CNT_W-1:0] tickCnt;
  logic [BIT_W-1:0] bitsLeft;
  logic [HLV_W-1:0] halvesLeft;
  logic             prevLoadN;
  logic             pending;
  logic             loadedLast;
  logic             bufEmptyR;
  logic             txEmptyR;

  logic             strobeRise;
  logic             tickEndBit;
  logic             tickEndHalf;
  logic             frameDone;
  logic             loadNow;
  logic [BIT_W-1:0] bitsAtLoad;
  logic [HLV_W-1:0] halvesAtLoad;

  always_comb begin
    strobeRise   = bufLoadN & ~prevLoadN;
    tickEndBit   = (tickCnt == CNT_W'(OSR - 1));
    tickEndHalf  = (tickCnt == CNT_W'(HALF - 1));
    frameDone    = (state == ST_STOP) && tickEndHalf && (halvesLeft == HLV_W'(1));
    loadNow      = pending && ((state == ST_IDLE) || frameDone);
    bitsAtLoad   = BIT_W'(MIN_LEN + 1) + BIT_W'(lenSel) + {{(BIT_W-1){1'b0}}, ~parOff};
    if (!stopSel)            halvesAtLoad = HLV_W'(2);
    else if (lenSel == '0)   halvesAtLoad = HLV_W'(3);
    else                     halvesAtLoad = HLV_W'(4);
    strobe.bufWr     = ~bufLoadN;
    strobe.loadFrame = loadNow;
    strobe.shiftBit  = (state == ST_BITS) && tickEndBit;
  end

  always_ff @(posedge clk) begin
    prevLoadN <= bufLoadN;
    if (mrst) begin
      state      <= ST_IDLE;
      tickCnt    <= '0;
      bitsLeft   <= '0;
      halvesLeft <= '0;
      pending    <= 1'b0;
      loadedLast <= 1'b0;
      bufEmptyR  <= 1'b1;
      txEmptyR   <= 1'b1;
    end else begin
      loadedLast <= loadNow;
      if (strobeRise)   pending <= 1'b1;
      else if (loadNow) pending <= 1'b0;
      if (strobeRise)      bufEmptyR <= 1'b0;
      else if (loadedLast) bufEmptyR <= 1'b1;
      if (loadNow) begin
        state      <= ST_BITS;
        tickCnt    <= '0;
        bitsLeft   <= bitsAtLoad;
        halvesLeft <= halvesAtLoad;
        txEmptyR   <= 1'b0;
      end else begin
        unique case (state)
          ST_BITS: begin
            tickCnt <= tickEndBit ? '0 : tickCnt + 1'b1;
            if (tickEndBit) begin
              bitsLeft <= bitsLeft - 1'b1;
              if (bitsLeft == BIT_W'(1)) state <= ST_STOP;
            end
          end
          ST_STOP: begin
            if (tickEndHalf) begin
              tickCnt    <= '0;
              halvesLeft <= halvesLeft - 1'b1;
              if (halvesLeft == HLV_W'(1)) begin
                state    <= ST_IDLE;
                txEmptyR <= 1'b1;
              end
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign bufEmpty = bufEmptyR;
  assign txEmpty  = txEmptyR;

  // R2: a sampled rising strobe empties nothing: buffer is marked full
  assert_rise_marks_full_R2: assert property (@(posedge clk) disable iff (mrst)
    strobeRise |=> !bufEmpty);

  // R3: a waiting character on an idle line never stays idle
  assert_idle_pending_starts_R3: assert property (@(posedge clk) disable iff (mrst)
    (state == ST_IDLE && pending) |=> (state == ST_BITS));

  // R8: stop time is between two and four half bits
  assert_stop_halves_R8: assert property (@(posedge clk) disable iff (mrst)
    (state == ST_STOP) |-> (halvesLeft >= HLV_W'(1) && halvesLeft <= HLV_W'(4)));

endmodule

// File: rtl/serial_tx_top.sv
module serial_tx_top
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              mrst,
  input  logic              cfgLoad,
  input  logic [1:0]        cfgLenSel,
  input  logic              cfgParOff,
  input  logic              cfgParEven,
  input  logic              cfgStopSel,
  input  logic              bufLoadN,
  input  logic [DATA_W-1:0] txData,
  output logic              serOut,
  output logic              bufEmpty,
  output logic              txEmpty
);

  txFmt_t    cfgIn;
  txFmt_t    fmtNow;
  txStrobe_t strobe;

  assign cfgIn = '{lenSel: cfgLenSel, parOff: cfgParOff, parEven: cfgParEven, stopSel: cfgStopSel};

  serial_tx_ctrl #(.DATA_W(DATA_W), .OSR(OSR)) u_ctrl (
    .clk      (clk),
    .mrst     (mrst),
    .bufLoadN (bufLoadN),
    .lenSel   (fmtNow.lenSel),
    .parOff   (fmtNow.parOff),
    .stopSel  (fmtNow.stopSel),
    .strobe   (strobe),
    .bufEmpty (bufEmpty),
    .txEmpty  (txEmpty)
  );

  serial_tx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .mrst    (mrst),
    .cfgLoad (cfgLoad),
    .cfgIn   (cfgIn),
    .txData  (txData),
    .strobe  (strobe),
    .fmtNow  (fmtNow),
    .serOut  (serOut)
  );

  // R9: an idle transmitter holds the line high
  assert_idle_line_high_R9: assert property (@(posedge clk) disable iff (mrst)
    txEmpty |-> serOut);

  // R3: leaving idle coincides with the start bit
  assert_leave_idle_start_R3: assert property (@(posedge clk) disable iff (mrst)
    $fell(txEmpty) |-> !serOut);

endmodule

// File: tb/serial_tx_top_tb.sv
module serial_tx_top_tb;

  localparam int DATA_W = 8;
  localparam int OSR    = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              mrst = 1'b1;
  logic              cfgLoad = 1'b0;
  logic [1:0]        cfgLenSel = 2'd0;
  logic              cfgParOff = 1'b0;
  logic              cfgParEven = 1'b0;
  logic              cfgStopSel = 1'b0;
  logic              bufLoadN = 1'b1;
  logic [DATA_W-1:0] txData = '0;
  logic              serOut, bufEmpty, txEmpty;

  serial_tx_top #(.DATA_W(DATA_W), .OSR(OSR)) u_dut (
    .clk(clk), .mrst(mrst), .cfgLoad(cfgLoad), .cfgLenSel(cfgLenSel),
    .cfgParOff(cfgParOff), .cfgParEven(cfgParEven), .cfgStopSel(cfgStopSel),
    .bufLoadN(bufLoadN), .txData(txData),
    .serOut(serOut), .bufEmpty(bufEmpty), .txEmpty(txEmpty)
  );

  // behavioural reference
  int                mLen, mParOff, mParEven, mStop;
  logic [DATA_W-1:0] mBuf;
  bit                mPrevN, mPending, mLoadedLast, mBufE, mTxE, mOut;
  bit                lineQ[$];
  bit                started = 0;
  int                vectors = 0;
  int                fails = 0;
  int                cycles = 0;
  string             curReq = "R1";

  task automatic buildFrame();
    int n;
    bit par;
    int stopLen;
    n   = 5 + mLen;
    par = 1'b0;
    for (int k = 0; k < OSR; k++) lineQ.push_back(1'b0);
    for (int i = 0; i < n; i++) begin
      par = par ^ mBuf[i];
      for (int k = 0; k < OSR; k++) lineQ.push_back(mBuf[i]);
    end
    if (mParOff == 0)
      for (int k = 0; k < OSR; k++) lineQ.push_back(mParEven != 0 ? par : ~par);
    if (mStop == 0)      stopLen = OSR;
    else if (mLen == 0)  stopLen = OSR * 3 / 2;
    else                 stopLen = 2 * OSR;
    for (int k = 0; k < stopLen; k++) lineQ.push_back(1'b1);
  endtask

  task automatic modelStep();
    bit tr, rise;
    if (mrst) begin
      mLen = 3; mParOff = 1; mParEven = 0; mStop = 0;
      mBuf = '0; mPending = 0; mLoadedLast = 0;
      mBufE = 1; mTxE = 1; mOut = 1;
      lineQ.delete();
    end else begin
      tr   = mPending && (lineQ.size() == 0);
      if (tr) buildFrame();
      rise = bufLoadN && !mPrevN;
      if (rise)             mBufE = 0;
      else if (mLoadedLast) mBufE = 1;
      mLoadedLast = tr;
      if (rise)    mPending = 1;
      else if (tr) mPending = 0;
      if (lineQ.size() > 0) begin
        mOut = lineQ.pop_front();
        mTxE = 0;
      end else begin
        mOut = 1;
        mTxE = 1;
      end
      if (cfgLoad) begin
        mLen = int'(cfgLenSel); mParOff = int'(cfgParOff);
        mParEven = int'(cfgParEven); mStop = int'(cfgStopSel);
      end
      if (!bufLoadN) mBuf = txData;
    end
    mPrevN = bufLoadN;
  endtask

  always @(posedge clk) begin
    modelStep();
    started = 1;
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected under 100000)", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      vectors++;
      if ({serOut, bufEmpty, txEmpty} !== {mOut, mBufE, mTxE}) begin
        fails++;
        $display("FAIL %s cycle %0d: serOut/bufEmpty/txEmpty actual %b%b%b expected %b%b%b",
                 curReq, cycles, serOut, bufEmpty, txEmpty, mOut, mBufE, mTxE);
      end
    end
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic setCfg(input int len, input bit pOff, input bit pEven, input bit stp);
    @(negedge clk);
    cfgLenSel = 2'(len); cfgParOff = pOff; cfgParEven = pEven; cfgStopSel = stp;
    cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
    cfgLenSel = ~cfgLenSel; cfgParOff = ~pOff; cfgParEven = ~pEven; cfgStopSel = ~stp;
  endtask

  task automatic sendChar(input logic [DATA_W-1:0] d);
    @(negedge clk);
    txData = d; bufLoadN = 1'b0;
    @(negedge clk);
    bufLoadN = 1'b1; txData = ~d;
  endtask

  task automatic waitIdle();
    for (int guard = 0; guard < 2000; guard++) begin
      @(negedge clk);
      if (lineQ.size() == 0 && !mPending && mBufE && mTxE) break;
    end
    repeat (2) @(negedge clk);
  endtask

  // idle load with explicit per-edge checks
  task automatic loadAndCheck(input logic [DATA_W-1:0] d);
    @(negedge clk);
    txData = d; bufLoadN = 1'b0;
    @(negedge clk);
    bufLoadN = 1'b1;
    @(negedge clk);
    check("R2", "bufEmpty after strobe rise", bufEmpty, 1'b0);
    check("R3", "line still idle before transfer", serOut, 1'b1);
    @(negedge clk);
    check("R3", "start bit after transfer", serOut, 1'b0);
    check("R3", "txEmpty cleared at transfer", txEmpty, 1'b0);
    @(negedge clk);
    check("R3", "bufEmpty set one clock later", bufEmpty, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "serOut in reset", serOut, 1'b1);
    check("R1", "bufEmpty in reset", bufEmpty, 1'b1);
    check("R1", "txEmpty in reset", txEmpty, 1'b1);
    mrst = 1'b0;

    curReq = "R10"; // default format 8 bits, no parity, 1 stop
    sendChar(8'hA5); waitIdle();

    curReq = "R3";
    loadAndCheck(8'h96); waitIdle();

    curReq = "R7";
    setCfg(3, 0, 1, 0); sendChar(8'h3C); waitIdle();
    setCfg(3, 0, 0, 0); sendChar(8'h3C); waitIdle();
    setCfg(2, 0, 1, 0); sendChar(8'h07); waitIdle();

    curReq = "R5";
    setCfg(0, 0, 0, 0); sendChar(8'h15); waitIdle();
    setCfg(1, 0, 1, 0); sendChar(8'h2B); waitIdle();
    setCfg(2, 1, 0, 0); sendChar(8'h61); waitIdle();

    curReq = "R6";
    setCfg(0, 1, 0, 0); sendChar(8'hE0); waitIdle();
    sendChar(8'hFF); waitIdle();
    setCfg(1, 0, 0, 0); sendChar(8'hC0); waitIdle();

    curReq = "R8";
    setCfg(0, 1, 0, 1); sendChar(8'h0A); waitIdle();
    setCfg(0, 0, 1, 1); sendChar(8'h1B); waitIdle();
    setCfg(1, 0, 1, 1); sendChar(8'h2D); waitIdle();
    setCfg(3, 1, 0, 1); sendChar(8'hF0); waitIdle();

    curReq = "R4";
    setCfg(3, 1, 0, 0);
    sendChar(8'h81);
    repeat (20) @(negedge clk);
    sendChar(8'h7E);
    for (int g = 0; g < 400 && !mBufE; g++) @(negedge clk);
    repeat (30) @(negedge clk);
    sendChar(8'h5A);
    waitIdle();

    curReq = "R9";
    setCfg(0, 0, 1, 1); sendChar(8'h11); sendChar(8'h0E); waitIdle();

    curReq = "R10"; // format change inside a frame and a held-open control register
    setCfg(3, 1, 0, 0);
    sendChar(8'h55);
    repeat (40) @(negedge clk);
    setCfg(0, 0, 1, 1);
    waitIdle();
    sendChar(8'h13); waitIdle();
    @(negedge clk);
    cfgLoad = 1'b1; cfgLenSel = 2'd1; cfgParOff = 1'b1; cfgStopSel = 1'b0;
    repeat (3) @(negedge clk);
    cfgLenSel = 2'd2; cfgParOff = 1'b0; cfgParEven = 1'b0;
    @(negedge clk);
    cfgLoad = 1'b0; cfgLenSel = 2'd0; cfgParOff = 1'b1;
    sendChar(8'h4C); waitIdle();

    curReq = "R2"; // several low samples: last value wins
    @(negedge clk);
    bufLoadN = 1'b0; txData = 8'h01;
    @(negedge clk); txData = 8'h02;
    @(negedge clk); txData = 8'h6D;
    @(negedge clk); bufLoadN = 1'b1; txData = 8'h00;
    waitIdle();

    curReq = "R1"; // reset in the middle of a frame
    setCfg(3, 0, 1, 1);
    sendChar(8'hC3);
    repeat (50) @(negedge clk);
    mrst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "serOut after mid-frame reset", serOut, 1'b1);
    check("R1", "txEmpty after mid-frame reset", txEmpty, 1'b1);
    mrst = 1'b0;
    sendChar(8'h3A); waitIdle();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule